// File: doc/BRIEF.md
# Serial Transmitter with In-Place Parity

This block sends asynchronous serial frames onto a single line. Each frame has a low start bit, a data field sent least significant bit first, and one high stop bit. The line rests high between frames. A clock enable at sixteen times the bit rate sets the timing, and every bit lasts sixteen of these enables. The block accepts a write of one byte, plus an extension bit, whenever it is not already sending.

Two data field lengths are available. The short field carries eight positions and the long field carries nine. With parity switched on, the block computes a parity bit and puts it in the top position of the field, so the frame does not grow. The data bit that would have gone in that position is dropped. In the short field the parity covers the seven low data bits. In the long field it covers all eight data bits. Either even or odd parity can be chosen. The field length, parity settings and data are captured when the write is accepted.

A busy output tells the user when a write can be issued. A one-cycle done pulse marks the end of the stop bit. The bit-rate enable comes from outside the block.

Top module: `sertx_parsub`

## Requirements
- R1: After reset, line_out is 1, busy is 0 and done is 0. Whenever busy is 0, line_out is 1.
- R2: A frame is a start bit of 0, then the data field with position 0 first, then a stop bit of 1. Each bit is held for exactly 16 cycles in which baud_tick is 1, counted from the cycle after the write is accepted.
- R3: With long_word=0 and par_en=0, the field has 8 positions and carries wr_data[7:0] unchanged.
- R4: With long_word=1 and par_en=0, the field has 9 positions. Positions 0 to 7 are wr_data[7:0] and position 8 is wr_ext.
- R5: With long_word=0 and par_en=1, positions 0 to 6 are wr_data[6:0]. Position 7 is the parity bit over wr_data[6:0], and wr_data[7] is not sent. With par_odd=0 the parity is even: 0x35 gives parity 0, and so does 0xB5.
- R6: With long_word=1 and par_en=1, positions 0 to 7 are wr_data[7:0]. Position 8 is the parity bit over wr_data[7:0], and wr_ext has no effect.
- R7: With par_odd=1, the parity bit makes the number of ones in the covered bits plus the parity bit odd. For example, 0x35 with long_word=0 gives parity 1.
- R8: A write (wr_valid=1) is accepted only in a cycle where busy is 0. busy is 1 from the next cycle on. A write attempted while busy is 1 has no effect on the frame being sent or on later frames.
- R9: After the 16th tick of the stop bit, done is 1 for exactly one cycle, and busy falls to 0 in that same cycle. done is never 1 at any other time.
- R10: Changes to wr_data, wr_ext, long_word, par_en or par_odd after a write is accepted do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Data byte |
| wr_ext | input | 1 | Ninth data bit, used with the long field when parity is off |
| long_word | input | 1 | 0: 8-position field, 1: 9-position field |
| par_en | input | 1 | Replace the top field position with parity |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| line_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the stop bit |

## Verification
The bench builds the block with its default values: an eight-bit data byte and sixteen ticks per bit. It supplies a tick on every second clock. At this rate both the ten-bit and the eleven-bit frame finish in a few hundred cycles, so every combination of field length and parity setting, including back-to-back frames, fits in a short run. The bench samples each bit at its eighth tick. The parity examples are chosen so that a dropped top data bit would read differently from the computed parity.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef struct packed {
        logic busy;
        logic done;
    } ctl_t;

    function automatic logic par_fix(input logic ones_odd, input logic want_odd);
        return ones_odd ^ want_odd;
    endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        bit_end = run && tick && (cnt_q == CW'(OSR - 1));
        cnt_d   = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int FRAME_W = DATA_W + 3,
    localparam int NW      = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               ext,
    input  logic               long_word,
    input  logic               par_en,
    input  logic               par_odd,
    output logic [FRAME_W-1:0] frame,
    output logic [NW-1:0]      nbits
);
    logic [DATA_W-2:0] low;
    logic              p_short, p_long, top_pos, ext_pos;

    always_comb begin
        low     = data[DATA_W-2:0];
        p_short = par_fix(^low, par_odd);
        p_long  = par_fix(^data, par_odd);
        top_pos = (!long_word && par_en) ? p_short : data[DATA_W-1];
        ext_pos = long_word ? (par_en ? p_long : ext) : 1'b1;
        frame   = {1'b1, ext_pos, top_pos, low, 1'b0};
        nbits   = long_word ? NW'(FRAME_W) : NW'(FRAME_W - 1);
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int FRAME_W = 11,
    localparam int NW     = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [NW-1:0]      nbits_in,
    output logic               line,
    output logic               last
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [NW-1:0]      left;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = frame_in;
            st_d.left = nbits_in;
        end else if (step) begin
            st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
            st_d.left = st_q.left - 1'b1;
        end
        line = st_q.sh[0];
        last = (st_q.left == NW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sertx_parsub.sv
module sertx_parsub
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ext,
    input  logic              long_word,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              line_out,
    output logic              busy,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int NW      = $clog2(FRAME_W + 1);

    ctl_t               ctl_d, ctl_q;
    logic               accept, bit_end, last;
    logic [FRAME_W-1:0] frame;
    logic [NW-1:0]      nbits;

    sertx_framer #(.DATA_W(DATA_W)) i_framer (
        .data      (wr_data),
        .ext       (wr_ext),
        .long_word (long_word),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .frame     (frame),
        .nbits     (nbits)
    );

    sertx_bitclk #(.OSR(OSR)) i_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.busy),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    sertx_shift #(.FRAME_W(FRAME_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (bit_end),
        .frame_in (frame),
        .nbits_in (nbits),
        .line     (line_out),
        .last     (last)
    );

    always_comb begin
        accept     = wr_valid && !ctl_q.busy;
        ctl_d.done = ctl_q.busy && bit_end && last;
        ctl_d.busy = ctl_q.busy;
        if (accept)          ctl_d.busy = 1'b1;
        else if (ctl_d.done) ctl_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.done;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic line_out,
    input logic busy,
    input logic done
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_out);

    a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !busy) |=> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r9_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind sertx_parsub sertx_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .line_out (line_out),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_sertx_parsub.sv
module test_sertx_parsub;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ext = 1'b0;
    logic       long_word = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       line_out, busy, done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    int tick_div = 0;

    typedef struct {
        logic [10:0] bits;
        int          nb;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    sertx_parsub i_sertx_parsub (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ext(wr_ext), .long_word(long_word),
        .par_en(par_en), .par_odd(par_odd), .line_out(line_out),
        .busy(busy), .done(done)
    );

    // tick on every second clock, updated after the edge
    always @(posedge clk) begin
        tick_div  <= (tick_div + 1) % 2;
        baud_tick <= (tick_div == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic item_t model(input logic [7:0] d, input logic e,
                                    input logic m, input logic pe,
                                    input logic po, input string tag);
        item_t it;
        logic  p7, p8;
        logic [8:0] pay;
        p7 = (^d[6:0]) ^ po;
        p8 = (^d) ^ po;
        if (!m) pay = {1'b1, pe ? p7 : d[7], d[6:0]};
        else    pay = {pe ? p8 : e, d};
        it.nb   = m ? 11 : 10;
        it.bits = m ? {1'b1, pay, 1'b0} : {2'b11, pay[7:0], 1'b0};
        it.tag  = tag;
        return it;
    endfunction

    task automatic send(input logic [7:0] d, input logic e, input logic m,
                        input logic pe, input logic po, input string tag,
                        input bit scramble);
        @(negedge clk);
        while (busy) @(negedge clk);
        wr_data = d; wr_ext = e; long_word = m; par_en = pe; par_odd = po;
        wr_valid = 1'b1;
        exp_q.push_back(model(d, e, m, pe, po, tag));
        @(negedge clk);
        wr_valid = 1'b0;
        if (scramble) begin
            // R10: inputs change after acceptance
            wr_data = ~d; wr_ext = ~e; long_word = ~m; par_en = ~pe; par_odd = ~po;
        end
    endtask

    // R8: write attempts while busy must be ignored
    task automatic poke_busy();
        @(negedge clk);
        while (!busy) @(negedge clk);
        repeat (40) @(negedge clk);
        wr_data = 8'hFF; wr_ext = 1'b0; long_word = 1'b1; par_en = 1'b0;
        wr_valid = 1'b1;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // monitor: decodes frames and compares against the scoreboard
    initial begin
        item_t it;
        int    k;
        forever begin
            if (rst_n && !line_out) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected frame start", 1, 0);
                    it.bits = 11'h7FE; it.nb = 10; it.tag = "R8";
                end else begin
                    it = exp_q.pop_front();
                end
                k = 0;
                for (int i = 0; i < it.nb; i++) begin
                    while (k < 16 * i + 8) begin
                        if (baud_tick) k++;
                        @(negedge clk);
                    end
                    check(line_out === it.bits[i], (i == 0 || i == it.nb - 1) ? "R2" : it.tag,
                          $sformatf("bit %0d", i), int'(line_out), int'(it.bits[i]));
                end
                check(busy === 1'b1 && done === 1'b0, "R9", "busy mid stop bit",
                      {busy, done}, 2'b10);
                while (k < 16 * it.nb) begin
                    if (baud_tick) k++;
                    @(negedge clk);
                end
                check(done === 1'b1 && busy === 1'b0, "R9", "done after stop",
                      {busy, done}, 2'b01);
                @(negedge clk);
                check(done === 1'b0, "R9", "done one cycle", int'(done), 0);
            end else begin
                @(negedge clk);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "in reset",
              {line_out, busy, done}, 3'b100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(line_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "after reset",
              {line_out, busy, done}, 3'b100);

        send(8'h35, 1'b0, 1'b0, 1'b0, 1'b0, "R3", 0);
        send(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, "R3", 0);
        send(8'h35, 1'b0, 1'b0, 1'b1, 1'b0, "R5", 0);
        send(8'hB5, 1'b0, 1'b0, 1'b1, 1'b0, "R5", 0);
        send(8'h35, 1'b0, 1'b0, 1'b1, 1'b1, "R7", 0);
        send(8'hA6, 1'b1, 1'b1, 1'b0, 1'b0, "R4", 0);
        send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R4", 0);
        send(8'h35, 1'b1, 1'b1, 1'b1, 1'b0, "R6", 0);
        send(8'h37, 1'b0, 1'b1, 1'b1, 1'b0, "R6", 0);
        send(8'h37, 1'b1, 1'b1, 1'b1, 1'b1, "R7", 0);
        send(8'h81, 1'b0, 1'b0, 1'b1, 1'b1, "R10", 1);
        send(8'h7E, 1'b1, 1'b1, 1'b0, 1'b0, "R10", 1);
        fork
            send(8'h29, 1'b0, 1'b0, 1'b0, 1'b0, "R8", 0);
            poke_busy();
        join
        send(8'h96, 1'b0, 1'b1, 1'b1, 1'b1, "R8", 0);

        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int c = 0; c < 400; c++) begin
            if (line_out !== 1'b1 || busy !== 1'b0) begin
                check(0, "R1", "idle line", {line_out, busy}, 2'b10);
                break;
            end
            @(negedge clk);
        end
        check(line_out === 1'b1 && busy === 1'b0, "R1", "idle after traffic",
              {line_out, busy}, 2'b10);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule